// File: doc/BRIEF.md
# Converter Power State Controller

This block sets the power of an eight-channel data converter. A shutdown input, which may change at any time with respect to the clock, chooses one of two power profiles. Each profile supplies a per-channel enable mask and a single bit that picks the deeper of two idle modes. The block turns these into per-channel power enables, enables for the reference, the clock-multiplier PLL, the duty-cycle equalizer and the bandgap, and a ready flag.

An idle mode is entered only when the chosen profile enables no channel. In the light idle mode the reference, PLL and equalizer stay powered, so the wake-up is short. In the deep idle mode only the bandgap stays on, so the wake-up is long. Both wake-up times are counted in clock cycles and set by parameters. The defaults are about 2 µs and about 10 ms at 50 MHz.

The profile fields come from configuration registers held elsewhere. The package gives their reset values: profile 0 is full power with every channel on, and profile 1 is a deep shutdown.

Top module: `adc_pwr_ctrl`

## Requirements
- R1: `shdn_async` passes through two synchronizing flops. A change driven just before clock edge k alters the state at edge k+2, so idle-mode outputs first appear after the third edge.
- R2: While the synchronized shutdown is 0, profile 0 (`p0_ch_mask`, `p0_deep`) governs. While it is 1, profile 1 governs.
- R3: In the active state, `ch_pwr_en` equals the governing mask, the reference, PLL, equalizer and bandgap enables are 1, and `ready` is 1. A change from one nonzero mask to another updates `ch_pwr_en` and keeps `ready` at 1.
- R4: An idle state is entered only when the governing mask is all zeros. The deep bit then selects it: 1 selects deep (sleep) and 0 selects light (nap).
- R5: In nap, `ch_pwr_en` is 0, the reference, PLL, equalizer and bandgap enables are 1, and `ready` is 0.
- R6: In sleep, every output is 0 except `bandgap_en`, which is 1.
- R7: Leaving nap for a nonzero mask spends NAP_WAKE_CYC cycles in a wake state. Leaving sleep spends SLEEP_WAKE_CYC cycles there. During the wake state `ch_pwr_en` equals the mask, the reference, PLL and equalizer enables are 1, and `ready` is 0. `ready` rises when the count expires.
- R8: During the wake state, a change of the governing mask or mode restarts the count at its full length. A switch to a sleep target goes straight to sleep.
- R9: Leaving sleep for a nap target passes through the wake state with the sleep count and then settles in nap. `ready` stays 0 throughout.
- R10: Reset puts the block in sleep with the synchronizer cleared. Once reset is released, it wakes with the sleep count.
- R11: With the package default profiles, shutdown 1 gives the sleep outputs and shutdown 0 gives full power with all channels on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_async | input | 1 | Profile select, not yet synchronized |
| p0_ch_mask | input | NUM_CH | Channel enables of profile 0 |
| p0_deep | input | 1 | Profile 0 idle choice: 1 sleep, 0 nap |
| p1_ch_mask | input | NUM_CH | Channel enables of profile 1 |
| p1_deep | input | 1 | Profile 1 idle choice: 1 sleep, 0 nap |
| ch_pwr_en | output | NUM_CH | Per-channel power enables |
| ref_en | output | 1 | Reference enable |
| pll_en | output | 1 | Clock-multiplier PLL enable |
| dce_en | output | 1 | Duty-cycle equalizer enable |
| bandgap_en | output | 1 | Bandgap enable |
| ready | output | 1 | Outputs valid after wake-up |

## Verification
The hardest case to reach from the ports is a target change that lands inside a running wake count. It must restart the count with the length of the mode being left, not the mode being entered. The bench reaches it by waking from sleep and then changing the profile 0 mask a few cycles into the count. It also enters sleep partway through a wake. Sleep-to-nap is a third path: its only visible trace is the length of time before nap settles. The bench measures each wake as the number of cycles until `ready` rises, so a count that is too short or too long shows up at the ports.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

  typedef enum logic [1:0] {
    PS_ACTIVE = 2'd0,
    PS_NAP    = 2'd1,
    PS_SLEEP  = 2'd2,
    PS_WAKING = 2'd3
  } pwr_state_e;

  typedef enum logic [1:0] {
    TM_ACTIVE = 2'd0,
    TM_NAP    = 2'd1,
    TM_SLEEP  = 2'd2
  } tgt_mode_e;

  // Reset values of the two profiles (all-on bit, deep bit)
  localparam logic DEF_P0_ALL_ON = 1'b1;
  localparam logic DEF_P0_DEEP   = 1'b0;
  localparam logic DEF_P1_ALL_ON = 1'b0;
  localparam logic DEF_P1_DEEP   = 1'b1;

  // Mode a profile asks for: active if any channel is on, else the idle choice
  function automatic tgt_mode_e pick_mode(input logic any_on, input logic deep);
    if (any_on)    return TM_ACTIVE;
    else if (deep) return TM_SLEEP;
    else           return TM_NAP;
  endfunction

  // Wake-up length in cycles for the mode being left
  function automatic int unsigned wake_len(input logic from_sleep,
                                           input int unsigned nap_cyc,
                                           input int unsigned sleep_cyc);
    return from_sleep ? sleep_cyc : nap_cyc;
  endfunction

endpackage

// File: rtl/adc_pwr_sync.sv
module adc_pwr_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/adc_pwr_profile_sel.sv
module adc_pwr_profile_sel
  import adc_pwr_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              sel,
  input  logic [NUM_CH-1:0] mask0,
  input  logic              deep0,
  input  logic [NUM_CH-1:0] mask1,
  input  logic              deep1,
  output logic [NUM_CH-1:0] mask,
  output tgt_mode_e         mode
);
  logic deep;

  always_comb begin
    mask = sel ? mask1 : mask0;
    deep = sel ? deep1 : deep0;
    mode = pick_mode(|mask, deep);
  end
endmodule

// File: rtl/adc_pwr_wake_timer.sv
module adc_pwr_wake_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= len - CNT_W'(1);
    else if (cnt != '0)  cnt <= cnt - CNT_W'(1);
  end

  assign done = (cnt == '0);

  // R7: the count stops at zero and never wraps
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt == '0) |=> cnt == '0);
endmodule

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl
  import adc_pwr_pkg::*;
#(
  parameter int unsigned NUM_CH         = 8,
  parameter int unsigned NAP_WAKE_CYC   = 100,
  parameter int unsigned SLEEP_WAKE_CYC = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shdn_async,
  input  logic [NUM_CH-1:0] p0_ch_mask,
  input  logic              p0_deep,
  input  logic [NUM_CH-1:0] p1_ch_mask,
  input  logic              p1_deep,
  output logic [NUM_CH-1:0] ch_pwr_en,
  output logic              ref_en,
  output logic              pll_en,
  output logic              dce_en,
  output logic              bandgap_en,
  output logic              ready
);
  localparam int unsigned WAKE_MAX = (NAP_WAKE_CYC > SLEEP_WAKE_CYC) ? NAP_WAKE_CYC : SLEEP_WAKE_CYC;
  localparam int unsigned CNT_W    = $clog2(WAKE_MAX + 1);
  localparam int unsigned KEY_W    = NUM_CH + 2;

  // Named internal events
  logic              shdn_s;
  logic [NUM_CH-1:0] sel_mask;
  tgt_mode_e         sel_mode;
  logic [KEY_W-1:0]  tgt_key, tgt_q;
  logic              tgt_changed;
  logic              wake_load, wake_done;
  logic              load_from_sleep;
  logic [CNT_W-1:0]  load_len;
  logic              from_sleep_q, from_sleep_d;
  pwr_state_e        state, state_d;

  adc_pwr_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(shdn_async), .q_sync(shdn_s)
  );

  adc_pwr_profile_sel #(.NUM_CH(NUM_CH)) u_sel (
    .sel(shdn_s), .mask0(p0_ch_mask), .deep0(p0_deep),
    .mask1(p1_ch_mask), .deep1(p1_deep),
    .mask(sel_mask), .mode(sel_mode)
  );

  adc_pwr_wake_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(wake_load), .len(load_len), .done(wake_done)
  );

  assign tgt_key     = {sel_mode, sel_mask};
  assign tgt_changed = (tgt_key != tgt_q);
  assign load_len    = CNT_W'(wake_len(load_from_sleep, NAP_WAKE_CYC, SLEEP_WAKE_CYC));

  // Next-state logic
  always_comb begin
    state_d         = state;
    wake_load       = 1'b0;
    from_sleep_d    = from_sleep_q;
    load_from_sleep = from_sleep_q;
    unique case (state)
      PS_ACTIVE: begin
        if (sel_mode == TM_SLEEP)    state_d = PS_SLEEP;
        else if (sel_mode == TM_NAP) state_d = PS_NAP;
      end
      PS_NAP: begin
        if (sel_mode == TM_SLEEP) state_d = PS_SLEEP;
        else if (sel_mode == TM_ACTIVE) begin
          state_d         = PS_WAKING;
          wake_load       = 1'b1;
          from_sleep_d    = 1'b0;
          load_from_sleep = 1'b0;
        end
      end
      PS_SLEEP: begin
        if (sel_mode != TM_SLEEP) begin
          state_d         = PS_WAKING;
          wake_load       = 1'b1;
          from_sleep_d    = 1'b1;
          load_from_sleep = 1'b1;
        end
      end
      PS_WAKING: begin
        if (sel_mode == TM_SLEEP)                       state_d = PS_SLEEP;
        else if (sel_mode == TM_NAP && !from_sleep_q)   state_d = PS_NAP;
        else if (tgt_changed)                           wake_load = 1'b1;
        else if (wake_done) state_d = (sel_mode == TM_NAP) ? PS_NAP : PS_ACTIVE;
      end
      default: state_d = PS_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= PS_SLEEP;
      from_sleep_q <= 1'b1;
      tgt_q        <= {TM_SLEEP, {NUM_CH{1'b0}}};
    end else begin
      state        <= state_d;
      from_sleep_q <= from_sleep_d;
      tgt_q        <= tgt_key;
    end
  end

  // Output decode
  always_comb begin
    ch_pwr_en  = '0;
    ref_en     = 1'b0;
    pll_en     = 1'b0;
    dce_en     = 1'b0;
    bandgap_en = 1'b1;
    ready      = 1'b0;
    unique case (state)
      PS_ACTIVE: begin
        ch_pwr_en = sel_mask;
        ref_en = 1'b1; pll_en = 1'b1; dce_en = 1'b1;
        ready  = 1'b1;
      end
      PS_NAP: begin
        ref_en = 1'b1; pll_en = 1'b1; dce_en = 1'b1;
      end
      PS_WAKING: begin
        ch_pwr_en = sel_mask;
        ref_en = 1'b1; pll_en = 1'b1; dce_en = 1'b1;
      end
      default: ;
    endcase
  end

  // R7: ready rises only out of the wake state once the count has expired
  a_r7_ready_after_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(state) == PS_WAKING && $past(wake_done)));

  // R8: a changed active target during wake keeps the block waking
  a_r8_restart_holds_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_WAKING && tgt_changed && sel_mode == TM_ACTIVE) |=> state == PS_WAKING);

  // R4: the active state is left only when no channel was requested
  a_r4_idle_only_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == PS_ACTIVE && state != PS_ACTIVE) |-> $past(sel_mask) == '0);

  // R9: a wake entered from sleep uses the sleep length
  a_r9_sleep_wake_tagged: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_WAKING && $past(state) == PS_SLEEP) |-> from_sleep_q);

endmodule

// File: tb/adc_pwr_ctrl_tb.sv
module adc_pwr_ctrl_tb;
  import adc_pwr_pkg::*;

  localparam int NCH = 8;
  localparam int NW  = 6;
  localparam int SW  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shdn = 1'b0;
  logic [NCH-1:0] m0, m1;
  logic d0, d1;
  logic [NCH-1:0] ch;
  logic ref_en, pll_en, dce_en, bg_en, ready;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  adc_pwr_ctrl #(.NUM_CH(NCH), .NAP_WAKE_CYC(NW), .SLEEP_WAKE_CYC(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .shdn_async(shdn),
    .p0_ch_mask(m0), .p0_deep(d0), .p1_ch_mask(m1), .p1_deep(d1),
    .ch_pwr_en(ch), .ref_en(ref_en), .pll_en(pll_en), .dce_en(dce_en),
    .bandgap_en(bg_en), .ready(ready)
  );

  // {ch, ref, pll, dce, bg, ready}
  function automatic logic [NCH+4:0] pat(input logic [NCH-1:0] c, input logic clocks_on,
                                         input logic rdy);
    return {c, clocks_on, clocks_on, clocks_on, 1'b1, rdy};
  endfunction

  function automatic logic [NCH+4:0] settled(input logic [NCH-1:0] mask, input logic deep);
    if (mask != '0) return pat(mask, 1'b1, 1'b1);
    else if (deep)  return pat('0, 1'b0, 1'b0);
    else            return pat('0, 1'b1, 1'b0);
  endfunction

  function automatic logic [NCH+4:0] seen();
    return {ch, ref_en, pll_en, dce_en, bg_en, ready};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    logic [NCH+4:0] exp_p;
    m0 = {NCH{DEF_P0_ALL_ON}}; d0 = DEF_P0_DEEP;
    m1 = {NCH{DEF_P1_ALL_ON}}; d1 = DEF_P1_DEEP;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10: reset holds sleep outputs
    check("R10", "reset outputs", 32'(seen()), 32'(pat('0, 1'b0, 1'b0)));
    rst_n = 1'b1;
    wait_ready(n);
    check("R10", "wake after reset", n, SW + 1);
    // R11 / R3: default profile 0 is full power
    check("R11", "default full power", 32'(seen()), 32'(pat('1, 1'b1, 1'b1)));

    // R1 / R6: entry into sleep at the third edge
    shdn = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "still active after two edges", ready, 1'b1);
    @(negedge clk);
    check("R6", "sleep outputs", 32'(seen()), 32'(pat('0, 1'b0, 1'b0)));
    check("R11", "default shutdown", 32'(seen()), 32'(settled(m1, d1)));

    // R7 / R1: wake from sleep
    shdn = 1'b0;
    wait_ready(n);
    check("R7", "sleep wake length", n, SW + 3);

    // R3: mask change within active keeps ready
    m0 = 8'h3C;
    @(negedge clk);
    check("R3", "new mask applied", 32'(seen()), 32'(pat(8'h3C, 1'b1, 1'b1)));
    n = 0;
    repeat (5) begin @(negedge clk); if (!ready) n++; end
    check("R3", "ready kept", n, 0);

    // R8: restart during a sleep wake
    shdn = 1'b1; repeat (4) @(negedge clk);
    shdn = 1'b0; repeat (3 + 5) @(negedge clk);
    check("R7", "waking outputs", 32'(seen()), 32'(pat(8'h3C, 1'b1, 1'b0)));
    m0 = 8'h81;
    wait_ready(n);
    check("R8", "restarted count", n, SW + 1);

    // R8: sleep target mid-wake goes straight to sleep
    shdn = 1'b1; repeat (4) @(negedge clk);
    shdn = 1'b0; repeat (3 + 4) @(negedge clk);
    shdn = 1'b1; repeat (3) @(negedge clk);
    check("R8", "sleep mid-wake", 32'(seen()), 32'(pat('0, 1'b0, 1'b0)));

    // R9: sleep to nap uses the sleep count and never raises ready
    m0 = '0; d0 = 1'b0; shdn = 1'b0;
    n = 0;
    repeat (SW + 2) begin @(negedge clk); if (ready) n++; end
    check("R9", "ready held low", n, 0);
    @(negedge clk);
    check("R5", "nap outputs", 32'(seen()), 32'(pat('0, 1'b1, 1'b0)));

    // R7: wake from nap uses the nap count
    m0 = 8'h81;
    @(negedge clk);
    check("R7", "nap waking channels", 32'(seen()), 32'(pat(8'h81, 1'b1, 1'b0)));
    wait_ready(n);
    check("R7", "nap wake length", n + 1, NW + 1);

    // R2 / R4: random profiles, checked once settled
    for (int i = 0; i < 40; i++) begin
      logic [NCH-1:0] ma, mb;
      ma = ($urandom % 3 == 0) ? '0 : NCH'($urandom);
      mb = ($urandom % 3 == 0) ? '0 : NCH'($urandom);
      m0 = ma; m1 = mb;
      d0 = 1'($urandom); d1 = 1'($urandom);
      shdn = 1'($urandom);
      repeat (SW + 8) @(negedge clk);
      exp_p = shdn ? settled(m1, d1) : settled(m0, d0);
      check(shdn ? "R2" : "R4", "random profile", 32'(seen()), 32'(exp_p));
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule